// File: doc/BRIEF.md
# Hysteresis Line Slicer and Bit Timing Recovery

This block turns a stream of periodic voltage samples from a two-level line into discrete bits. Each raw converter code is scaled to millivolts and passed through a slicer. The slicer has a fixed centre and a configurable hysteresis band. A sample inside the band keeps the previous line level and raises a blank strobe for that sample, so a downstream driver can hold its outputs quiet while the line is ambiguous.

Bit timing comes from a run-length counter that restarts on every level change. After a change, the first decision point falls half a bit period later, which is the middle of the first bit. Each later decision point follows one full bit period after the one before, so the sampling phase stays centred as long as transitions keep arriving. At every decision point the block emits a bit strobe that carries the held level.

The controller is a small state machine with three named states. ST_CLEAR is entered on reset or on a configuration change, with the counter, threshold and level all zero. ST_HUNT is entered from ST_CLEAR on the next accepted sample and means no transition has been seen yet. ST_LOCKED is entered from ST_HUNT or ST_CLEAR on the first transition and is held until the next clear. A configuration change moves any state back to ST_CLEAR.

Top module: `line_bit_recovery`

## Requirements
- R1: A 12-bit sample code c is converted to millivolts as (c * 13300) >> 12, truncated; for example code 769 gives 2496 mV, 770 gives 2500 mV, 2618 gives 8500 mV and 2619 gives 8504 mV.
- R2: With hysteresis width H, a sample below 5500 - H/2 mV sets the level to 0, a sample above 5500 + H/2 mV sets it to 1, and a sample on or between those bounds keeps the level unchanged.
- R3: The blank output pulses high for one cycle, one clock after the accepted sample, exactly when that sample lay on or inside the hysteresis bounds; it may coincide with a bit strobe.
- R4: The bit strobe and the blank strobe are high only in the cycle right after a clock edge that accepted a sample (sample_valid high), and are low at all other times.
- R5: A sample that changes the level emits no bit, sets the run counter to 0 and sets the commit threshold to floor(P/2), where P is the bit period in samples. The first bit after it is therefore emitted on the floor(P/2)-th following sample.
- R6: Every accepted sample increments the run counter; when the counter, after the increment, is at or above the commit threshold and the level did not change, one bit is emitted and the threshold grows by P.
- R7: The emitted bit value equals the level held at the decision point.
- R8: After reset the outputs are low, the level is 0 and both the counter and the threshold are 0. The first sample that leaves the level at 0 therefore emits a 0 bit at once.
- R9: A change on either configuration input (hysteresis width or bit period) clears the counter, the threshold and the level, and produces no strobe. A sample accepted in the same cycle as the change is discarded.
- R10: The 16-bit run counter and threshold saturate at 65535 and do not wrap. Once both are saturated on a constant line, a bit is emitted on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | A new sample is present on sample_code this cycle |
| sample_code | input | 12 | Raw converter code |
| cfg_hyst_mv | input | 16 | Hysteresis band width in millivolts (default 6000) |
| cfg_period | input | 16 | Bit period in samples (default 40) |
| bit_valid | output | 1 | One-cycle strobe: a bit was recovered |
| bit_value | output | 1 | Value of the recovered bit, valid with bit_valid |
| blank | output | 1 | One-cycle strobe: the last sample was inside the band |

## Verification
The blank strobe and the bit strobe can both fire from the same sample: an in-band sample keeps the level, so it still advances the run counter and can land exactly on a commit point. The bench provokes this by feeding mid-band codes across a decision point, both right after a configuration clear, where the threshold is zero, and in steady state. The scoreboard then expects both strobes in the same cycle, with the bit carrying the held level. A transition can never coincide with a bit, and a checker property confirms that a level change always leaves the counter at zero with no strobe.

// File: rtl/lbr_pkg.sv
`timescale 1ns/1ps
package lbr_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } lbr_state_e;

    typedef struct packed {
        logic level;
        logic in_band;
    } lbr_slice_t;

endpackage

// File: rtl/lbr_mv_scale.sv
`timescale 1ns/1ps
module lbr_mv_scale #(
    parameter int SAMPLE_W    = 12,
    parameter int MV_W        = 16,
    parameter int SCALE_MUL   = 13300,
    parameter int SCALE_SHIFT = 12
) (
    input  logic [SAMPLE_W-1:0] code,
    output logic [MV_W-1:0]     mv
);
    localparam int MUL_W  = $clog2(SCALE_MUL + 1);
    localparam int PROD_W = SAMPLE_W + MUL_W;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] shifted;

    always_comb begin
        product = PROD_W'(code) * PROD_W'(SCALE_MUL);
        shifted = product >> SCALE_SHIFT;
        mv      = shifted[MV_W-1:0];
    end
endmodule

// File: rtl/lbr_slicer.sv
`timescale 1ns/1ps
module lbr_slicer
    import lbr_pkg::*;
#(
    parameter int MV_W      = 16,
    parameter int CENTRE_MV = 5500
) (
    input  logic [MV_W-1:0] mv,
    input  logic [MV_W-1:0] hyst_mv,
    input  logic            held_level,
    output lbr_slice_t      slice
);
    localparam int CMP_W = MV_W + 2;

    logic signed [CMP_W-1:0] offset;
    logic signed [CMP_W-1:0] half_band;
    logic signed [CMP_W-1:0] neg_half;

    always_comb begin
        offset    = $signed({2'b00, mv}) - $signed(CMP_W'(CENTRE_MV));
        half_band = $signed({2'b00, hyst_mv >> 1});
        neg_half  = -half_band;
        if (offset < neg_half) begin
            slice.level   = 1'b0;
            slice.in_band = 1'b0;
        end else if (offset > half_band) begin
            slice.level   = 1'b1;
            slice.in_band = 1'b0;
        end else begin
            slice.level   = held_level;
            slice.in_band = 1'b1;
        end
    end
endmodule

// File: rtl/lbr_run_timer.sv
`timescale 1ns/1ps
module lbr_run_timer
    import lbr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_chg,
    input  logic             sample_valid,
    input  lbr_slice_t       slice,
    input  logic [CNT_W-1:0] period,
    output lbr_state_e       state,
    output logic             level_q,
    output logic [CNT_W-1:0] run_len,
    output logic [CNT_W-1:0] commit,
    output logic             bit_valid,
    output logic             bit_value,
    output logic             blank
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    lbr_state_e       state_n;
    logic             level_n;
    logic [CNT_W-1:0] len_n;
    logic [CNT_W-1:0] commit_n;
    logic [CNT_W-1:0] len_inc;
    logic [CNT_W:0]   commit_sum;
    logic [CNT_W-1:0] commit_adv;
    logic             emit_c;
    logic             blank_c;

    // saturating helpers
    always_comb begin
        len_inc    = (run_len == CNT_MAX) ? CNT_MAX : run_len + 1'b1;
        commit_sum = {1'b0, commit} + {1'b0, period};
        commit_adv = commit_sum[CNT_W] ? CNT_MAX : commit_sum[CNT_W-1:0];
    end

    // next-state and datapath decision
    always_comb begin
        state_n  = state;
        level_n  = level_q;
        len_n    = run_len;
        commit_n = commit;
        emit_c   = 1'b0;
        blank_c  = 1'b0;
        if (cfg_chg) begin
            state_n  = ST_CLEAR;
            level_n  = 1'b0;
            len_n    = '0;
            commit_n = '0;
        end else if (sample_valid) begin
            blank_c = slice.in_band;
            unique case (state)
                ST_CLEAR, ST_HUNT, ST_LOCKED: begin
                    if (slice.level != level_q) begin
                        level_n  = slice.level;
                        len_n    = '0;
                        commit_n = period >> 1;
                        state_n  = ST_LOCKED;
                    end else begin
                        len_n = len_inc;
                        if (len_inc >= commit) begin
                            emit_c   = 1'b1;
                            commit_n = commit_adv;
                        end
                        if (state == ST_CLEAR) begin
                            state_n = ST_HUNT;
                        end
                    end
                end
                default: state_n = ST_CLEAR;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            level_q <= 1'b0;
            run_len <= '0;
            commit  <= '0;
        end else begin
            state   <= state_n;
            level_q <= level_n;
            run_len <= len_n;
            commit  <= commit_n;
        end
    end

    // output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
            blank     <= 1'b0;
        end else begin
            bit_valid <= emit_c;
            bit_value <= emit_c ? level_q : 1'b0;
            blank     <= blank_c;
        end
    end
endmodule

// File: rtl/line_bit_recovery.sv
`timescale 1ns/1ps
module line_bit_recovery
    import lbr_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int MV_W        = 16,
    parameter int CNT_W       = 16,
    parameter int SCALE_MUL   = 13300,
    parameter int SCALE_SHIFT = 12,
    parameter int CENTRE_MV   = 5500,
    parameter int DEF_HYST    = 6000,
    parameter int DEF_PERIOD  = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_code,
    input  logic [MV_W-1:0]     cfg_hyst_mv,
    input  logic [CNT_W-1:0]    cfg_period,
    output logic                bit_valid,
    output logic                bit_value,
    output logic                blank
);
    logic [MV_W-1:0]  hyst_q;
    logic [CNT_W-1:0] period_q;
    logic             cfg_chg;
    logic [MV_W-1:0]  sample_mv;
    lbr_slice_t       slice;
    lbr_state_e       state;
    logic             level_q;
    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] commit;

    always_comb begin
        cfg_chg = (cfg_hyst_mv != hyst_q) || (cfg_period != period_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hyst_q   <= MV_W'(DEF_HYST);
            period_q <= CNT_W'(DEF_PERIOD);
        end else begin
            hyst_q   <= cfg_hyst_mv;
            period_q <= cfg_period;
        end
    end

    lbr_mv_scale #(
        .SAMPLE_W   (SAMPLE_W),
        .MV_W       (MV_W),
        .SCALE_MUL  (SCALE_MUL),
        .SCALE_SHIFT(SCALE_SHIFT)
    ) u_scale (
        .code(sample_code),
        .mv  (sample_mv)
    );

    lbr_slicer #(
        .MV_W     (MV_W),
        .CENTRE_MV(CENTRE_MV)
    ) u_slicer (
        .mv        (sample_mv),
        .hyst_mv   (hyst_q),
        .held_level(level_q),
        .slice     (slice)
    );

    lbr_run_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_chg     (cfg_chg),
        .sample_valid(sample_valid),
        .slice       (slice),
        .period      (period_q),
        .state       (state),
        .level_q     (level_q),
        .run_len     (run_len),
        .commit      (commit),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .blank       (blank)
    );
endmodule

// File: rtl/lbr_checker.sv
`timescale 1ns/1ps
module lbr_checker
    import lbr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             cfg_chg,
    input lbr_state_e       state,
    input logic             level_q,
    input logic [CNT_W-1:0] run_len,
    input logic [CNT_W-1:0] commit,
    input logic [CNT_W-1:0] period_q,
    input logic             bit_valid,
    input logic             bit_value,
    input logic             blank
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R4
    bit_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        bit_valid |-> $past(sample_valid));

    // R3
    blank_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        blank |-> ($past(sample_valid) && !$past(cfg_chg)));

    // R5
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(sample_valid) && !$past(cfg_chg) && (level_q != $past(level_q)))
        |-> (run_len == '0 && commit == (period_q >> 1) && !bit_valid));

    // R7
    bit_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        bit_valid |-> (bit_value == level_q));

    // R9
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $past(cfg_chg) |-> (run_len == '0 && commit == '0 && !level_q && !bit_valid && !blank));

    // R9
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (state == ST_CLEAR) |-> (run_len == '0 && commit == '0));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(run_len) == CNT_MAX && $past(sample_valid) && !$past(cfg_chg)
         && level_q == $past(level_q)) |-> (run_len == CNT_MAX));
endmodule

bind line_bit_recovery lbr_checker #(.CNT_W(16)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .cfg_chg     (cfg_chg),
    .state       (state),
    .level_q     (level_q),
    .run_len     (run_len),
    .commit      (commit),
    .period_q    (period_q),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .blank       (blank)
);

// File: tb/line_bit_recovery_bench.sv
`timescale 1ns/1ps
module line_bit_recovery_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_code = '0;
    logic [15:0] cfg_hyst_mv = 16'd6000;
    logic [15:0] cfg_period = 16'd40;
    logic        bit_valid;
    logic        bit_value;
    logic        blank;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_bit_recovery u_line_bit_recovery (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .sample_code (sample_code),
        .cfg_hyst_mv (cfg_hyst_mv),
        .cfg_period  (cfg_period),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .blank       (blank)
    );

    typedef struct {
        logic  bv;
        logic  bval;
        logic  blk;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    string cur_tag = "R8";

    // reference model state
    int m_h = 6000;
    int m_p = 40;
    int m_lvl = 0;
    int m_len = 0;
    int m_commit = 0;

    function automatic exp_t model_step(int code, int h, int p);
        exp_t e;
        int mv, off, half, nl;
        e.bv = 0; e.bval = 0; e.blk = 0; e.tag = cur_tag;
        if (h != m_h || p != m_p) begin
            m_h = h; m_p = p; m_lvl = 0; m_len = 0; m_commit = 0;
            return e;
        end
        mv   = (code * 13300) >>> 12;
        off  = mv - 5500;
        half = m_h / 2;
        if (off < -half) nl = 0;
        else if (off > half) nl = 1;
        else begin nl = m_lvl; e.blk = 1; end
        if (nl != m_lvl) begin
            m_lvl = nl; m_len = 0; m_commit = m_p / 2;
        end else begin
            m_len = (m_len >= 65535) ? 65535 : m_len + 1;
            if (m_len >= m_commit) begin
                e.bv = 1; e.bval = m_lvl[0];
                m_commit = (m_commit + m_p > 65535) ? 65535 : m_commit + m_p;
            end
        end
        return e;
    endfunction

    // driver: one sample per call, valid left high
    task automatic send(int code);
        sample_valid = 1'b1;
        sample_code  = code[11:0];
        exp_q.push_back(model_step(code, cfg_hyst_mv, cfg_period));
        @(negedge clk);
    endtask

    task automatic send_n(int code, int n);
        for (int i = 0; i < n; i++) send(code);
    endtask

    task automatic idle(int n);
        sample_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(int h, int p);
        sample_valid = 1'b0;
        cfg_hyst_mv  = h[15:0];
        cfg_period   = p[15:0];
        void'(model_step(0, h, p));
        @(negedge clk);
    endtask

    task automatic send_with_cfg(int code, int h, int p);
        cfg_hyst_mv = h[15:0];
        cfg_period  = p[15:0];
        send(code);
    endtask

    // monitor
    logic took = 1'b0;
    always @(posedge clk) took <= rst_n && sample_valid;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (took) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R4: strobe with empty scoreboard, actual bv=%0b blk=%0b expected none",
                             bit_valid, blank);
                end else begin
                    e = exp_q.pop_front();
                    total++;
                    if (bit_valid !== e.bv || (e.bv && bit_value !== e.bval) || blank !== e.blk) begin
                        bad++;
                        $display("FAIL %s: actual bv=%0b val=%0b blk=%0b expected bv=%0b val=%0b blk=%0b",
                                 e.tag, bit_valid, bit_value, blank, e.bv, e.bval, e.blk);
                    end
                end
            end else if (bit_valid || blank) begin
                total++; bad++;
                $display("FAIL R4: strobe without a sample, actual bv=%0b blk=%0b expected 0 0",
                         bit_valid, blank);
            end
        end
    end

    // watchdog
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state at the outputs
        total++;
        if (bit_valid || blank || bit_value) begin
            bad++;
            $display("FAIL R8: actual bv=%0b val=%0b blk=%0b expected 0 0 0", bit_valid, bit_value, blank);
        end

        // R8: first low sample emits a 0 at once
        cur_tag = "R8";
        send_n(0, 2);
        cur_tag = "R6";
        send_n(0, 43);
        idle(3);
        cur_tag = "R4";
        send(0);
        idle(2);

        // R5 / R7: square pattern at period 40
        cur_tag = "R5";
        send_n(4095, 70);
        cur_tag = "R7";
        send_n(0, 45);
        send_n(4095, 30);
        idle(1);
        send_n(0, 25);

        // R1 / R2 boundaries at H=6000 (level 0 now)
        cur_tag = "R1";
        send(2618);
        send(2619);
        send(770);
        send(769);
        cur_tag = "R2";
        send(2618);
        send(4095);
        send(770);
        send(1654);

        // R3: mid-band codes across a decision point
        cur_tag = "R3";
        send_n(1654, 45);

        // R9: config clear with level 1 beforehand
        cur_tag = "R9";
        send_n(4095, 3);
        set_cfg(2000, 10);
        send(1654);
        send_n(1654, 3);
        cur_tag = "R6";
        send_n(4095, 12);
        send_n(0, 7);
        cur_tag = "R9";
        send_with_cfg(4095, 6000, 7);
        send(1654);
        cur_tag = "R5";
        send_n(4095, 10);
        send_n(0, 10);
        idle(2);

        // R10: saturation on a long constant run
        set_cfg(6000, 30000);
        cur_tag = "R10";
        send_n(0, 65545);
        idle(3);

        done = 1'b1;
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R4: actual %0d unmatched items expected 0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule